// File: doc/BRIEF.md
# Fractional-Rate System Tick Counter

This block keeps a 64-bit system time count that runs from a fast core clock yet advances at a slower, programmable tick rate. On every enabled core clock a 32-bit fraction is added into an accumulator. The carry out of that accumulator bumps the 64-bit count by one. The increment is programmed as `(2^32 * tick_rate) / core_clock_hz`, in units of 2^-32 tick. Any source clock can therefore produce a fixed nominal tick rate, such as 1 MHz.

Software reaches the block through a plain register port. A write takes effect on the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`. A small control state machine decides in each cycle whether the count advances. Its states are:

- `ST_IDLE`: counting is disabled.
- `ST_RUN`: the count advances.
- `ST_DBG_HALT`: frozen by the debug-halt input.
- `ST_FC_HOLD`: frozen and acknowledging a frequency-change request.

The next state is chosen by a fixed priority, the same from every state:

1. A pending frequency-change request goes to `ST_FC_HOLD`.
2. Otherwise, a clear enable goes to `ST_IDLE`.
3. Otherwise, halt-on-debug set together with the debug-halt input goes to `ST_DBG_HALT`.
4. Otherwise the next state is `ST_RUN`.

A written rate is first staged. The increment in use takes the staged value in each clock spent in `ST_IDLE`, and on the clock that leaves `ST_FC_HOLD`. The tick-rate identification register is plain storage for software.

Top module: `frac_tick_counter`

## Requirements
- R1: Register addresses are: 0 control, 1 status, 2 rate, 3 tick-rate id, 4 count. After reset, control, status and count read 0, and rate and tick-rate id read their reset parameters (default 0).
- R2: While control bit 0 (enable) is clear, the count holds its value, and a write to the count still lands on the next edge.
- R3: In `ST_RUN` each clock adds the active rate to a 32-bit fraction. After a count write and N counting clocks, the count equals the written value plus floor(N * rate / 2^32). A rate of 0 never advances the count, and a rate of 0xFFFFFFFF advances it N-1 times in N clocks.
- R4: A write to the count register loads the count and clears the fraction, so the next carry needs a full 2^32 of accumulated rate.
- R5: When a count write and an accumulator carry fall in the same clock, the written value is the result.
- R6: With control bit 1 (halt-on-debug) set and the debug-halt input high, the count holds from the second clock on, and status bit 1 reads 1. After the input falls, status bit 1 returns to 0.
- R7: With control bit 1 clear, the debug-halt input has no effect: counting continues and status bit 1 stays 0.
- R8: Setting control bit 8 (frequency-change request) sets status bit 8 exactly one clock after the control write. The count holds while the acknowledge is up, and the acknowledge drops one clock after the request is cleared.
- R9: A rate written while counting reads back at once but does not change the increment. It takes effect when the frequency-change request is cleared, starting with the second clock after the clearing write.
- R10: The tick-rate id register (32 bits) reads back what was written and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_halt_i | input | 1 | Debug-halt request from the debug logic |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from `reg_addr` |

## Verification
Two events can fall in the same clock: a software write to the count register and a carry out of the fractional accumulator. The bench provokes this by running with a rate of 0xFFFFFFFF after a few clocks have left the fraction non-zero, so that a carry is due in nearly every cycle. It then writes the count. The written value must read back exactly on the following cycle, with no extra tick added. The clearing of the fraction is judged separately with a half rate: the written value must hold for one clock before the next tick.

// File: rtl/tick_pkg.sv
`timescale 1ns/1ps
package tick_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_DBG_HALT = 2'd2,
        ST_FC_HOLD  = 2'd3
    } tick_state_e;

    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] A_STAT  = 3'd1;
    localparam logic [REG_AW-1:0] A_RATE  = 3'd2;
    localparam logic [REG_AW-1:0] A_IDENT = 3'd3;
    localparam logic [REG_AW-1:0] A_COUNT = 3'd4;

    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_HOD_BIT  = 1;
    localparam int unsigned CTRL_FCRQ_BIT = 8;
    localparam int unsigned STAT_DBG_BIT  = 1;
    localparam int unsigned STAT_ACK_BIT  = 8;

endpackage

// File: rtl/tick_ctrl_fsm.sv
`timescale 1ns/1ps
module tick_ctrl_fsm
    import tick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic hod_i,
    input  logic fcreq_i,
    input  logic dbg_halt_i,
    output logic run_o,
    output logic dbg_halted_o,
    output logic fc_ack_o,
    output logic rate_load_o
);

    tick_state_e state_q, state_d;

    // Transition selection: request hold > disable > debug halt > run
    always_comb begin
        if (fcreq_i) begin
            state_d = ST_FC_HOLD;
        end else if (!en_i) begin
            state_d = ST_IDLE;
        end else if (hod_i && dbg_halt_i) begin
            state_d = ST_DBG_HALT;
        end else begin
            state_d = ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        run_o        = 1'b0;
        dbg_halted_o = 1'b0;
        fc_ack_o     = 1'b0;
        rate_load_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rate_load_o = 1'b1;
            end
            ST_RUN: begin
                run_o = 1'b1;
            end
            ST_DBG_HALT: begin
                dbg_halted_o = 1'b1;
            end
            ST_FC_HOLD: begin
                fc_ack_o    = 1'b1;
                rate_load_o = !fcreq_i;
            end
        endcase
    end

    // R8: acknowledge one clock after the request is seen
    a_r8_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        fcreq_i |=> fc_ack_o);

    // R8: acknowledge only ever follows a request
    a_r8_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        fc_ack_o |-> $past(fcreq_i));

    a_r6_debug_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && hod_i && dbg_halt_i && !fcreq_i) |=> (dbg_halted_o && !run_o));

    a_r7_debug_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !hod_i && !fcreq_i) |=> run_o);

    a_r2_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !fcreq_i) |=> !run_o);

endmodule

// File: rtl/tick_regs.sv
`timescale 1ns/1ps
module tick_regs
    import tick_pkg::*;
#(
    parameter int unsigned CNT_W    = 64,
    parameter int unsigned FRAC_W   = 32,
    parameter logic [FRAC_W-1:0] RATE_RST  = '0,
    parameter logic [FRAC_W-1:0] IDENT_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [FRAC_W-1:0] wdata_i,
    input  logic              rate_load_i,
    input  logic              dbg_halted_i,
    input  logic              fc_ack_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              en_o,
    output logic              hod_o,
    output logic              fcreq_o,
    output logic              cnt_wr_o,
    output logic [FRAC_W-1:0] rate_act_o,
    output logic [CNT_W-1:0]  rdata_o
);

    logic              en_q, hod_q, fcreq_q;
    logic [FRAC_W-1:0] rate_stage_q, rate_act_q, ident_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q         <= 1'b0;
            hod_q        <= 1'b0;
            fcreq_q      <= 1'b0;
            rate_stage_q <= RATE_RST;
            ident_q      <= IDENT_RST;
        end else if (we_i) begin
            if (addr_i == A_CTRL) begin
                en_q    <= wdata_i[CTRL_EN_BIT];
                hod_q   <= wdata_i[CTRL_HOD_BIT];
                fcreq_q <= wdata_i[CTRL_FCRQ_BIT];
            end
            if (addr_i == A_RATE) begin
                rate_stage_q <= wdata_i;
            end
            if (addr_i == A_IDENT) begin
                ident_q <= wdata_i;
            end
        end
    end

    // The increment in use only follows the staged value at safe points
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_act_q <= RATE_RST;
        end else if (rate_load_i) begin
            rate_act_q <= rate_stage_q;
        end
    end

    assign en_o       = en_q;
    assign hod_o      = hod_q;
    assign fcreq_o    = fcreq_q;
    assign rate_act_o = rate_act_q;
    assign cnt_wr_o   = we_i && (addr_i == A_COUNT);

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: begin
                rdata_o[CTRL_EN_BIT]   = en_q;
                rdata_o[CTRL_HOD_BIT]  = hod_q;
                rdata_o[CTRL_FCRQ_BIT] = fcreq_q;
            end
            A_STAT: begin
                rdata_o[STAT_DBG_BIT] = dbg_halted_i;
                rdata_o[STAT_ACK_BIT] = fc_ack_i;
            end
            A_RATE:  rdata_o = CNT_W'(rate_stage_q);
            A_IDENT: rdata_o = CNT_W'(ident_q);
            A_COUNT: rdata_o = count_i;
            default: rdata_o = '0;
        endcase
    end

    // R9: the increment in use moves only on a load point
    a_r9_rate_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_load_i |=> $stable(rate_act_q));

    a_r9_rate_takes_staged: assert property (@(posedge clk) disable iff (!rst_n)
        rate_load_i |=> (rate_act_q == $past(rate_stage_q)));

endmodule

// File: rtl/tick_accum.sv
`timescale 1ns/1ps
module tick_accum #(
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned FRAC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [FRAC_W-1:0] rate_i,
    input  logic              wr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  count_o
);

    localparam int unsigned SUM_W = FRAC_W + 1;

    logic [FRAC_W-1:0] frac_q;
    logic [CNT_W-1:0]  count_q;
    logic [SUM_W-1:0]  sum;

    assign sum = {1'b0, frac_q} + {1'b0, rate_i};

    // A count write overrides any carry produced in the same clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac_q  <= '0;
            count_q <= '0;
        end else if (wr_i) begin
            frac_q  <= '0;
            count_q <= wdata_i;
        end else if (run_i) begin
            frac_q  <= sum[FRAC_W-1:0];
            count_q <= count_q + CNT_W'(sum[FRAC_W]);
        end
    end

    assign count_o = count_q;

    a_r4_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (count_q == $past(wdata_i)) && (frac_q == '0));

    a_r3_step_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !wr_i) |=> ((count_q - $past(count_q)) <= CNT_W'(1)));

    a_r3_zero_rate_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && rate_i == '0) |=> $stable(count_q));

    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !run_i) |=> ($stable(count_q) && $stable(frac_q)));

endmodule

// File: rtl/frac_tick_counter.sv
`timescale 1ns/1ps
module frac_tick_counter
    import tick_pkg::*;
#(
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned FRAC_W = 32,
    parameter logic [FRAC_W-1:0] RATE_RST  = '0,
    parameter logic [FRAC_W-1:0] IDENT_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_halt_i,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata
);

    logic              en, hod, fcreq, cnt_wr;
    logic              run, dbg_halted, fc_ack, rate_load;
    logic [FRAC_W-1:0] rate_act;
    logic [CNT_W-1:0]  count;

    tick_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .hod_i        (hod),
        .fcreq_i      (fcreq),
        .dbg_halt_i   (dbg_halt_i),
        .run_o        (run),
        .dbg_halted_o (dbg_halted),
        .fc_ack_o     (fc_ack),
        .rate_load_o  (rate_load)
    );

    tick_regs #(
        .CNT_W     (CNT_W),
        .FRAC_W    (FRAC_W),
        .RATE_RST  (RATE_RST),
        .IDENT_RST (IDENT_RST)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (reg_we),
        .addr_i       (reg_addr),
        .wdata_i      (reg_wdata[FRAC_W-1:0]),
        .rate_load_i  (rate_load),
        .dbg_halted_i (dbg_halted),
        .fc_ack_i     (fc_ack),
        .count_i      (count),
        .en_o         (en),
        .hod_o        (hod),
        .fcreq_o      (fcreq),
        .cnt_wr_o     (cnt_wr),
        .rate_act_o   (rate_act),
        .rdata_o      (reg_rdata)
    );

    tick_accum #(
        .CNT_W  (CNT_W),
        .FRAC_W (FRAC_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .rate_i  (rate_act),
        .wr_i    (cnt_wr),
        .wdata_i (reg_wdata),
        .count_o (count)
    );

endmodule

// File: tb/test_frac_tick_counter.sv
`timescale 1ns/1ps
module test_frac_tick_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_halt_i = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];
    event        sample_ev;

    always #2.5 clk = ~clk;

    frac_tick_counter i_frac_tick_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .dbg_halt_i (dbg_halt_i),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata)
    );

    // Monitor: pops the expected item and compares it with the read port
    initial begin
        forever begin
            @(sample_ev);
            #0.2;
            begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (reg_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // Driver: called just after a falling edge; the write lands on the next rise
    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [63:0] e, input string t);
        reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> sample_ev;
        #0.4;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd(3'd0, 64'd0, "R1 control");
        expect_rd(3'd1, 64'd0, "R1 status");
        expect_rd(3'd4, 64'd0, "R1 count");
        expect_rd(3'd2, 64'd0, "R1 rate");
        expect_rd(3'd3, 64'd0, "R1 tick id");

        // R2 disabled: count write lands, then holds
        wr(3'd4, 64'd100);
        wr(3'd2, 64'h4000_0000);
        wait_cyc(6);
        expect_rd(3'd4, 64'd100, "R2 hold while disabled");

        // R3 quarter rate, 10 clocks -> +2
        wr(3'd0, 64'h1);
        wait_cyc(2);
        wr(3'd4, 64'd1000);
        wait_cyc(10);
        expect_rd(3'd4, 64'd1002, "R3 quarter rate");

        // R3/R4 half rate
        wr(3'd0, 64'h0);
        wr(3'd2, 64'h8000_0000);
        wait_cyc(1);
        wr(3'd0, 64'h1);
        wr(3'd4, 64'd2000);
        wait_cyc(3);
        expect_rd(3'd4, 64'd2001, "R3 half rate odd clocks");
        wr(3'd4, 64'd3000);
        wait_cyc(1);
        expect_rd(3'd4, 64'd3000, "R4 fraction cleared by write");
        wait_cyc(1);
        expect_rd(3'd4, 64'd3001, "R3 half rate second clock");

        // R5 count write against a carry in the same clock
        wr(3'd0, 64'h0);
        wr(3'd2, 64'hFFFF_FFFF);
        wait_cyc(1);
        wr(3'd0, 64'h1);
        wait_cyc(2);
        wr(3'd4, 64'd5000);
        expect_rd(3'd4, 64'd5000, "R5 write wins over carry");
        wait_cyc(4);
        expect_rd(3'd4, 64'd5003, "R3 near-unity rate");

        // R7 debug input ignored without halt-on-debug
        dbg_halt_i = 1'b1;
        wr(3'd4, 64'd6000);
        wait_cyc(4);
        expect_rd(3'd4, 64'd6003, "R7 counting continues");
        expect_rd(3'd1, 64'd0, "R7 status stays clear");
        dbg_halt_i = 1'b0;

        // R6 halt on debug
        wr(3'd0, 64'h3);
        dbg_halt_i = 1'b1;
        wait_cyc(1);
        wr(3'd4, 64'd7000);
        wait_cyc(6);
        expect_rd(3'd4, 64'd7000, "R6 count frozen");
        expect_rd(3'd1, 64'h2, "R6 status halted");
        dbg_halt_i = 1'b0;
        wait_cyc(2);
        expect_rd(3'd1, 64'h0, "R6 status released");
        wr(3'd0, 64'h1);

        // R10 tick id write has no effect on counting
        wr(3'd4, 64'd8000);
        wr(3'd3, 64'h000F_4240);
        wait_cyc(3);
        expect_rd(3'd4, 64'd8003, "R10 counting unaffected");
        expect_rd(3'd3, 64'h000F_4240, "R10 readback");

        // R9 rate write while running is only staged
        wr(3'd2, 64'h4000_0000);
        wr(3'd4, 64'd9000);
        wait_cyc(4);
        expect_rd(3'd4, 64'd9003, "R9 old rate still in use");
        expect_rd(3'd2, 64'h4000_0000, "R9 staged readback");

        // R8 frequency-change handshake, then R9 new rate
        wr(3'd0, 64'h101);
        expect_rd(3'd1, 64'h0, "R8 no ack in request clock");
        wait_cyc(1);
        expect_rd(3'd1, 64'h100, "R8 ack one clock later");
        wr(3'd4, 64'd10000);
        wait_cyc(5);
        expect_rd(3'd4, 64'd10000, "R8 count frozen during hold");
        wr(3'd0, 64'h1);
        expect_rd(3'd1, 64'h100, "R8 ack held in clearing clock");
        wait_cyc(5);
        expect_rd(3'd4, 64'd10001, "R9 new rate after release");
        expect_rd(3'd1, 64'h0, "R8 ack dropped");

        wait_cyc(2);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule